// File: doc/BRIEF.md
# Error-Checked RAM Termination Generator

This block is the slave-side cycle terminator for a RAM whose read data passes through an error checker before it is trusted. A bus master raises `acc_req` for the length of an access. The checker reports its verdict with a one-cycle `chk_done` strobe, and `chk_err` is valid in that same cycle. From these inputs the block drives three active-low termination outputs: `ack_n` (acknowledge), `berr_n` (bus error) and `halt_n` (halt). In the retry policies it also emits `fix_req`, a single-cycle request for a correction write-back to the RAM. The write-back engine answers with `wb_done`.

A 2-bit configuration input selects one of four policies:

| `mode_cfg` | Acknowledge timing | Action on bad data |
|---|---|---|
| 0 | deferred until the check | bus error together with halt, so the master retries |
| 1 | deferred until the check | bus error only, so the master takes an exception |
| 2 | early, before the check | bus error only, on the next clock |
| 3 | early, before the check | bus error together with halt, on the next clock |

The early policies save the wait for the check on every good access. The deferred policies never acknowledge data that has not been checked. Only one automatic retry is allowed per original access.

The control is a seven-state machine:

- IDLE. Exits to EARLY_ACK or WAIT_CHK on `acc_req`.
- WAIT_CHK and EARLY_ACK. Exit to TERM_OK on a clean check. On an error they exit to RETRY_HALT when a retry is allowed, and to TERM_ERR otherwise. They return to IDLE if the strobe is dropped.
- TERM_OK and TERM_ERR. Return to IDLE on strobe removal.
- RETRY_HALT. On `wb_done` it moves to RETRY_REL while the strobe is still high, and to IDLE otherwise.
- RETRY_REL. Returns to IDLE on strobe removal.

Top module: `ecc_term_gen`

## Requirements
- R1: After reset `ack_n`, `berr_n` and `halt_n` are high and `fix_req` is low.
- R2: `mode_cfg` is decoded as 0 = deferred/retry, 1 = deferred/exception, 2 = early/exception, 3 = early/retry. It is sampled only in IDLE on the edge that starts an access, and changes during an access have no effect on that access.
- R3: In a deferred mode `ack_n` stays high until `chk_done` is sampled. With `chk_err`=0, `ack_n` goes low on that same edge and stays low while `acc_req` is high.
- R4: In an early mode `ack_n` goes low on the first edge that samples `acc_req` high, before any check result arrives.
- R5: In an exception mode, a sampled `chk_done` with `chk_err`=1 drives `berr_n` low and `ack_n` high on that edge, with `halt_n` high. `berr_n` stays low while `acc_req` is high.
- R6: In a retry mode, a sampled `chk_done` with `chk_err`=1 drives `berr_n` and `halt_n` low together and `ack_n` high on that edge. `fix_req` is high for exactly that one cycle.
- R7: `halt_n` stays low until `wb_done` is sampled and goes high on that edge. `berr_n` stays low afterwards while `acc_req` is still high.
- R8: On the edge after `acc_req` is sampled low, `ack_n` and `berr_n` are high. A pending halt is not released by strobe removal.
- R9: An error on the access that follows a retry (the first access after RETRY_HALT/RETRY_REL) is reported as a plain bus error: `berr_n` low, `halt_n` high, no `fix_req`.
- R10: `ack_n` and `berr_n` are never low in the same cycle, and `halt_n` falls only together with `berr_n` low.
- R11: `chk_done` received outside an access has no effect on the outputs or on the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cfg | input | 2 | Termination policy select |
| acc_req | input | 1 | Master access strobe, high during an access |
| chk_done | input | 1 | One-cycle check-complete strobe |
| chk_err | input | 1 | Check verdict, 1 = data in error, valid with `chk_done` |
| wb_done | input | 1 | Correction write-back complete |
| ack_n | output | 1 | Acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| halt_n | output | 1 | Halt, active low |
| fix_req | output | 1 | One-cycle correction write-back request |

## Verification
The bench goes after the retry budget first. A design that forgets the first retry would assert halt again on the retried access's error, and the master would loop forever. It also switches `mode_cfg` in the middle of an access: a design that re-reads the mode outside IDLE would acknowledge early, or would drop the halt, partway through the access. It drops the strobe while a write-back is still pending, which exposes a design that releases halt too soon or keeps driving bus error after the master has left. Finally, it sends a stray `chk_done` while idle, which catches a machine that moves without a live strobe.

// File: rtl/ecc_term_pkg.sv
package ecc_term_pkg;

    parameter int MODE_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CHK,
        ST_EARLY_ACK,
        ST_TERM_OK,
        ST_TERM_ERR,
        ST_RETRY_HALT,
        ST_RETRY_REL
    } term_state_t;

    typedef struct packed {
        logic early_ack;
        logic retry_on_err;
    } term_policy_t;

    function automatic term_policy_t decode_mode(input logic [MODE_W-1:0] m);
        term_policy_t p;
        unique case (m)
            2'd0:    begin p.early_ack = 1'b0; p.retry_on_err = 1'b1; end
            2'd1:    begin p.early_ack = 1'b0; p.retry_on_err = 1'b0; end
            2'd2:    begin p.early_ack = 1'b1; p.retry_on_err = 1'b0; end
            default: begin p.early_ack = 1'b1; p.retry_on_err = 1'b1; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ecc_term_mode.sv
module ecc_term_mode
    import ecc_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_idle,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_cfg,
    output term_policy_t      policy
);

    term_policy_t live_pol;
    term_policy_t held_pol;

    assign live_pol = decode_mode(mode_cfg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_pol <= '0;
        end else if (start) begin
            held_pol <= live_pol;
        end
    end

    assign policy = in_idle ? live_pol : held_pol;

endmodule

// File: rtl/ecc_term_fsm.sv
module ecc_term_fsm
    import ecc_term_pkg::*;
#(
    parameter int RETRY_MAX = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_req,
    input  logic         chk_done,
    input  logic         chk_err,
    input  logic         wb_done,
    input  term_policy_t policy,
    output term_state_t  state,
    output term_state_t  nxt
);

    localparam int RCNT_W = (RETRY_MAX < 1) ? 1 : $clog2(RETRY_MAX + 1);

    logic retry_left;
    logic enter_retry;
    logic end_access;

    assign enter_retry = (nxt == ST_RETRY_HALT) && (state != ST_RETRY_HALT);
    assign end_access  = (nxt == ST_IDLE) && (state != ST_IDLE) &&
                         (state != ST_RETRY_HALT) && (state != ST_RETRY_REL);

    generate
        if (RETRY_MAX > 0) begin : g_retry_cnt
            logic [RCNT_W-1:0] rcnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rcnt <= '0;
                end else if (end_access) begin
                    rcnt <= '0;
                end else if (enter_retry) begin
                    rcnt <= rcnt + 1'b1;
                end
            end
            assign retry_left = (rcnt < RCNT_W'(RETRY_MAX));
        end else begin : g_no_retry
            assign retry_left = 1'b0;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (acc_req) begin
                    nxt = policy.early_ack ? ST_EARLY_ACK : ST_WAIT_CHK;
                end
            end
            ST_WAIT_CHK, ST_EARLY_ACK: begin
                if (!acc_req) begin
                    nxt = ST_IDLE;
                end else if (chk_done) begin
                    if (!chk_err) begin
                        nxt = ST_TERM_OK;
                    end else if (policy.retry_on_err && retry_left) begin
                        nxt = ST_RETRY_HALT;
                    end else begin
                        nxt = ST_TERM_ERR;
                    end
                end
            end
            ST_TERM_OK, ST_TERM_ERR, ST_RETRY_REL: begin
                if (!acc_req) begin
                    nxt = ST_IDLE;
                end
            end
            ST_RETRY_HALT: begin
                if (wb_done) begin
                    nxt = acc_req ? ST_RETRY_REL : ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ecc_term_drv.sv
module ecc_term_drv
    import ecc_term_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  term_state_t state,
    input  term_state_t nxt,
    input  logic        acc_req,
    output logic        ack_n,
    output logic        berr_n,
    output logic        halt_n,
    output logic        fix_req
);

    logic ack_d;
    logic berr_d;
    logic halt_d;
    logic fix_d;

    always_comb begin
        ack_d  = (nxt == ST_EARLY_ACK) || (nxt == ST_TERM_OK);
        berr_d = (nxt == ST_TERM_ERR) ||
                 (((nxt == ST_RETRY_HALT) || (nxt == ST_RETRY_REL)) && acc_req);
        halt_d = (nxt == ST_RETRY_HALT);
        fix_d  = (nxt == ST_RETRY_HALT) && (state != ST_RETRY_HALT);
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_n   <= 1'b1;
            berr_n  <= 1'b1;
            halt_n  <= 1'b1;
            fix_req <= 1'b0;
        end else begin
            ack_n   <= ~ack_d;
            berr_n  <= ~berr_d;
            halt_n  <= ~halt_d;
            fix_req <= fix_d;
        end
    end

endmodule

// File: rtl/ecc_term_gen.sv
module ecc_term_gen
    import ecc_term_pkg::*;
#(
    parameter int RETRY_MAX = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_cfg,
    input  logic       acc_req,
    input  logic       chk_done,
    input  logic       chk_err,
    input  logic       wb_done,
    output logic       ack_n,
    output logic       berr_n,
    output logic       halt_n,
    output logic       fix_req
);

    term_state_t  state;
    term_state_t  nxt;
    term_policy_t policy;
    logic         in_idle;

    assign in_idle = (state == ST_IDLE);

    ecc_term_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_idle  (in_idle),
        .start    (in_idle && acc_req),
        .mode_cfg (mode_cfg),
        .policy   (policy)
    );

    ecc_term_fsm #(.RETRY_MAX(RETRY_MAX)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_req  (acc_req),
        .chk_done (chk_done),
        .chk_err  (chk_err),
        .wb_done  (wb_done),
        .policy   (policy),
        .state    (state),
        .nxt      (nxt)
    );

    ecc_term_drv u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .nxt     (nxt),
        .acc_req (acc_req),
        .ack_n   (ack_n),
        .berr_n  (berr_n),
        .halt_n  (halt_n),
        .fix_req (fix_req)
    );

endmodule

// File: rtl/ecc_term_chk.sv
module ecc_term_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_req,
    input logic wb_done,
    input logic ack_n,
    input logic berr_n,
    input logic halt_n,
    input logic fix_req
);

    AST_ACK_BERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ack_n && !berr_n)); // R10

    AST_HALT_WITH_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_n) |-> !berr_n); // R10

    AST_STROBE_DROP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (ack_n && berr_n)); // R8

    AST_FIX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fix_req |=> !fix_req); // R6

    AST_FIX_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        fix_req |-> (!halt_n && !berr_n && ack_n)); // R6

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_n && !wb_done) |=> !halt_n); // R7

    AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_n && wb_done) |=> halt_n); // R7

endmodule

bind ecc_term_gen ecc_term_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_req (acc_req),
    .wb_done (wb_done),
    .ack_n   (ack_n),
    .berr_n  (berr_n),
    .halt_n  (halt_n),
    .fix_req (fix_req)
);

// File: tb/tb_ecc_term_gen.sv
`timescale 1ns/1ps
module tb_ecc_term_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_cfg = 2'd0;
    logic       acc_req = 1'b0;
    logic       chk_done = 1'b0;
    logic       chk_err = 1'b0;
    logic       wb_done = 1'b0;
    logic       ack_n, berr_n, halt_n, fix_req;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    ecc_term_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .acc_req(acc_req),
        .chk_done(chk_done), .chk_err(chk_err), .wb_done(wb_done),
        .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n), .fix_req(fix_req)
    );

    // {mode[1:0], err, err_on_retry, exp_early, exp_retry}
    localparam logic [5:0] VEC [0:9] = '{
        6'b00_0_0_0_1, 6'b00_1_0_0_1, 6'b00_1_1_0_1,
        6'b01_0_0_0_0, 6'b01_1_0_0_0,
        6'b10_0_0_1_0, 6'b10_1_0_1_0,
        6'b11_0_0_1_1, 6'b11_1_0_1_1, 6'b11_1_1_1_1
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts at a negedge with the block idle, ends at a negedge idle
    task automatic run_access(input logic [1:0] m, input logic e,
                              input logic early, input logic do_retry);
        mode_cfg = m;
        acc_req  = 1'b1;
        @(negedge clk);
        check(early ? "R4 early ack" : "R3 ack held", ack_n, early ? 0 : 1);
        @(negedge clk);
        check("R3/R4 ack before check", ack_n, early ? 0 : 1);
        check("R10 no berr before check", berr_n, 1);
        chk_done = 1'b1;
        chk_err  = e;
        @(negedge clk);
        chk_done = 1'b0;
        chk_err  = 1'b0;
        if (!e) begin
            check("R3 ack on good data", ack_n, 0);
            check("R3 berr high", berr_n, 1);
            check("R3 halt high", halt_n, 1);
        end else if (do_retry) begin
            check("R6 berr low", berr_n, 0);
            check("R6 halt low", halt_n, 0);
            check("R6 ack high", ack_n, 1);
            check("R6 fix_req pulse", fix_req, 1);
            @(negedge clk);
            check("R6 fix_req one cycle", fix_req, 0);
            check("R7 halt held", halt_n, 0);
            @(negedge clk);
            check("R7 halt held no wb_done", halt_n, 0);
            wb_done = 1'b1;
            @(negedge clk);
            wb_done = 1'b0;
            check("R7 halt released", halt_n, 1);
            check("R7 berr kept", berr_n, 0);
        end else begin
            check("R5/R9 berr low", berr_n, 0);
            check("R5/R9 halt high", halt_n, 1);
            check("R5/R9 ack high", ack_n, 1);
            check("R5/R9 no fix_req", fix_req, 0);
        end
        @(negedge clk);
        acc_req = 1'b0;
        @(negedge clk);
        check("R8 ack negated", ack_n, 1);
        check("R8 berr negated", berr_n, 1);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 ack_n reset", ack_n, 1);
        check("R1 berr_n reset", berr_n, 1);
        check("R1 halt_n reset", halt_n, 1);
        check("R1 fix_req reset", fix_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 table walk
        for (int i = 0; i < 10; i++) begin
            logic [1:0] m;
            m = VEC[i][5:4];
            run_access(m, VEC[i][3], VEC[i][1], VEC[i][0] & VEC[i][3]);
            if (VEC[i][0] && VEC[i][3]) begin
                run_access(m, VEC[i][2], VEC[i][1], 1'b0); // R9 retried access
            end
        end

        // R11: stray check result while idle
        chk_done = 1'b1;
        chk_err  = 1'b1;
        @(negedge clk);
        chk_done = 1'b0;
        chk_err  = 1'b0;
        check("R11 berr idle", berr_n, 1);
        check("R11 halt idle", halt_n, 1);
        check("R11 ack idle", ack_n, 1);
        run_access(2'd1, 1'b0, 1'b0, 1'b0);

        // R2: mode change during access is ignored
        mode_cfg = 2'd0;
        acc_req  = 1'b1;
        @(negedge clk);
        mode_cfg = 2'd2;
        @(negedge clk);
        check("R2 no early ack after mode change", ack_n, 1);
        chk_done = 1'b1;
        chk_err  = 1'b1;
        @(negedge clk);
        chk_done = 1'b0;
        chk_err  = 1'b0;
        check("R2 latched retry mode halts", halt_n, 0);
        check("R2 latched retry fix_req", fix_req, 1);

        // R8: strobe dropped while halt pending
        acc_req = 1'b0;
        @(negedge clk);
        check("R8 berr negated on drop", berr_n, 1);
        check("R8 halt kept on drop", halt_n, 0);
        @(negedge clk);
        check("R7 halt kept until wb_done", halt_n, 0);
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
        check("R7 halt released after drop", halt_n, 1);
        @(negedge clk);
        // R9 second error after retry is plain bus error (mode 3 selected now)
        run_access(2'd3, 1'b1, 1'b1, 1'b0);
        // budget restored for a fresh access
        run_access(2'd3, 1'b1, 1'b1, 1'b1);
        run_access(2'd3, 1'b0, 1'b1, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule